// File: doc/BRIEF.md
# Decimal Correction Unit

This block fixes up the contents of an 8-bit accumulator byte (AL) and its high companion byte (AH) after binary arithmetic on decimal data. Five corrections share one datapath. Two handle unpacked digits (one digit per byte), after an addition or a subtraction. Two handle packed digits (two digits per byte), after an addition or a subtraction. The fifth folds a two-digit unpacked value into a single binary byte, ready for a divide.

The caller presents an operation code, the two bytes and the incoming carry (CF) and auxiliary carry (AF), and pulses `start`. On the next clock edge the corrected bytes and the updated flags are registered, and `done` goes high for that one cycle. When no start is given, the results hold their values. Any flag that an operation leaves undefined is driven to 0.

Top module: `dau_top`

## Requirements
- R1: While `rst` is high, and after it is released until the first start, `done` is 0 and every data and flag output is 0.
- R2: A `start` seen at a clock edge registers that operation's results at that same edge, and `done` is 1 for the following cycle only. A clock edge with `start` low clears `done` and leaves every result output unchanged.
- R3: Op code 0 (unpacked add fix) adjusts when AL[3:0] > 9 or AF = 1. It then adds 6 to AL, adds 1 to AH (modulo 256) and sets AF and CF. Otherwise AH is unchanged and AF and CF are 0. In both cases AL[7:4] of the result is 0.
- R4: Op code 1 (unpacked subtract fix) uses the same test as R3. When it adjusts, it subtracts 6 from AL and 1 from AH (modulo 256) and sets AF and CF. The result has AL[7:4] = 0.
- R5: Op code 2 (packed add fix) first adds 6 to AL when AL[3:0] > 9 or AF = 1, and sets AF only in that case. It then adds 0x60 when the original AL > 0x99 or CF = 1, and sets CF only in that case. AH passes through unchanged.
- R6: Op code 3 (packed subtract fix) follows the same rules as R5, but subtracts 6 and 0x60 instead of adding them.
- R7: For op codes 2, 3 and 4, the flags are set from the new AL: PF = 1 when it has an even number of set bits, SF = bit 7, and ZF = 1 when it is zero.
- R8: Op code 4 (pre-divide fold) makes AL = (AH*10 + AL) mod 256 and AH = 0.
- R9: Flags an operation leaves undefined are 0. For op codes 0 and 1 these are PF, SF and ZF. For op code 4 they are AF and CF.
- R10: Op codes 5, 6 and 7 pass AL and AH through unchanged and clear all five flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Apply the operation this cycle |
| op | input | 3 | Operation code (see R3 to R10) |
| al_in | input | 8 | Low accumulator byte |
| ah_in | input | 8 | High companion byte |
| cf_in | input | 1 | Incoming carry flag |
| af_in | input | 1 | Incoming auxiliary carry flag |
| al_out | output | 8 | Corrected low byte |
| ah_out | output | 8 | Corrected high byte |
| cf_out | output | 1 | Carry flag result |
| af_out | output | 1 | Auxiliary carry result |
| pf_out | output | 1 | Parity flag result (1 = even count of ones) |
| sf_out | output | 1 | Sign flag result |
| zf_out | output | 1 | Zero flag result |
| done | output | 1 | One-cycle result strobe |

## Verification
The packed fixes can apply the low-nibble correction and the high correction in one operation. In that case the second step works on the output of the first, while its test looks at the original byte. The sweep provokes this with every AL value and every carry combination. It also covers bytes such as 0x9A, where the first step wraps to 0xA0 and the second carries out to 0x00, and the bench model reproduces each step in sequence. The unpacked fixes likewise combine an AL correction with an AH increment or decrement, and AH values of 0x00 and 0xFF are used to reach the wrap at both ends.

// File: rtl/dau_pkg.sv
package dau_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  typedef enum logic [2:0] {
    OP_UADD   = 3'd0,
    OP_USUB   = 3'd1,
    OP_PADD   = 3'd2,
    OP_PSUB   = 3'd3,
    OP_PREDIV = 3'd4
  } dau_op_e;

  typedef struct packed {
    logic [BYTE_W-1:0] al;
    logic [BYTE_W-1:0] ah;
    logic              cf;
    logic              af;
    logic              pf;
    logic              sf;
    logic              zf;
  } dau_res_t;
endpackage

// File: rtl/dau_flag_calc.sv
module dau_flag_calc
  import dau_pkg::*;
(
  input  logic [BYTE_W-1:0] val,
  output logic              pf,
  output logic              sf,
  output logic              zf
);
  always_comb begin
    pf = ~(^val);
    sf = val[BYTE_W-1];
    zf = (val == '0);
  end
endmodule

// File: rtl/dau_unpacked.sv
module dau_unpacked
  import dau_pkg::*;
#(
  parameter int BASE = 10,
  parameter bit SUB  = 1'b0
) (
  input  logic [BYTE_W-1:0] al,
  input  logic [BYTE_W-1:0] ah,
  input  logic              af,
  output dau_res_t          res
);
  localparam logic [NIB_W-1:0]  NIB_MAX = NIB_W'(BASE - 1);
  localparam logic [BYTE_W-1:0] CORR    = BYTE_W'((1 << NIB_W) - BASE);
  localparam logic [BYTE_W-1:0] ONE     = BYTE_W'(1);

  logic              adj;
  logic [BYTE_W-1:0] al_fix;
  logic [BYTE_W-1:0] ah_fix;
  logic [BYTE_W-1:0] al_sel;

  always_comb begin
    adj = (al[NIB_W-1:0] > NIB_MAX) | af;
    if (SUB) begin
      al_fix = al - CORR;
      ah_fix = ah - ONE;
    end else begin
      al_fix = al + CORR;
      ah_fix = ah + ONE;
    end
    al_sel = adj ? al_fix : al;
    res    = '0;
    res.al = {{(BYTE_W-NIB_W){1'b0}}, al_sel[NIB_W-1:0]};
    res.ah = adj ? ah_fix : ah;
    res.cf = adj;
    res.af = adj;
  end
endmodule

// File: rtl/dau_packed.sv
module dau_packed
  import dau_pkg::*;
#(
  parameter int BASE = 10,
  parameter bit SUB  = 1'b0
) (
  input  logic [BYTE_W-1:0] al,
  input  logic [BYTE_W-1:0] ah,
  input  logic              af,
  input  logic              cf,
  output dau_res_t          res
);
  localparam logic [NIB_W-1:0]  NIB_MAX = NIB_W'(BASE - 1);
  localparam logic [BYTE_W-1:0] LO_CORR = BYTE_W'((1 << NIB_W) - BASE);
  localparam logic [BYTE_W-1:0] HI_CORR = BYTE_W'(((1 << NIB_W) - BASE) << NIB_W);
  localparam logic [BYTE_W-1:0] HI_LIM  = BYTE_W'(((BASE - 1) << NIB_W) + (BASE - 1));

  logic              lo_adj;
  logic              hi_adj;
  logic [BYTE_W-1:0] step1;
  logic [BYTE_W-1:0] step2;
  logic              f_pf;
  logic              f_sf;
  logic              f_zf;

  always_comb begin
    lo_adj = (al[NIB_W-1:0] > NIB_MAX) | af;
    hi_adj = (al > HI_LIM) | cf;
    if (SUB) begin
      step1 = lo_adj ? al - LO_CORR : al;
      step2 = hi_adj ? step1 - HI_CORR : step1;
    end else begin
      step1 = lo_adj ? al + LO_CORR : al;
      step2 = hi_adj ? step1 + HI_CORR : step1;
    end
  end

  dau_flag_calc u_flags (
    .val (step2),
    .pf  (f_pf),
    .sf  (f_sf),
    .zf  (f_zf)
  );

  always_comb begin
    res    = '0;
    res.al = step2;
    res.ah = ah;
    res.af = lo_adj;
    res.cf = hi_adj;
    res.pf = f_pf;
    res.sf = f_sf;
    res.zf = f_zf;
  end
endmodule

// File: rtl/dau_prediv.sv
module dau_prediv
  import dau_pkg::*;
#(
  parameter int BASE = 10
) (
  input  logic [BYTE_W-1:0] al,
  input  logic [BYTE_W-1:0] ah,
  output dau_res_t          res
);
  localparam logic [BYTE_W-1:0] MULT = BYTE_W'(BASE);

  logic [BYTE_W-1:0] folded;
  logic              f_pf;
  logic              f_sf;
  logic              f_zf;

  always_comb folded = ah * MULT + al;

  dau_flag_calc u_flags (
    .val (folded),
    .pf  (f_pf),
    .sf  (f_sf),
    .zf  (f_zf)
  );

  always_comb begin
    res    = '0;
    res.al = folded;
    res.pf = f_pf;
    res.sf = f_sf;
    res.zf = f_zf;
  end
endmodule

// File: rtl/dau_top.sv
module dau_top
  import dau_pkg::*;
#(
  parameter int BASE = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [BYTE_W-1:0] al_in,
  input  logic [BYTE_W-1:0] ah_in,
  input  logic              cf_in,
  input  logic              af_in,
  output logic [BYTE_W-1:0] al_out,
  output logic [BYTE_W-1:0] ah_out,
  output logic              cf_out,
  output logic              af_out,
  output logic              pf_out,
  output logic              sf_out,
  output logic              zf_out,
  output logic              done
);
  localparam int NDIR = 2;

  dau_res_t unp_res [NDIR];
  dau_res_t pak_res [NDIR];
  dau_res_t div_res;
  dau_res_t nxt;
  dau_res_t res_q;
  logic     done_q;

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    dau_unpacked #(.BASE(BASE), .SUB(g == 1)) u_unp (
      .al  (al_in),
      .ah  (ah_in),
      .af  (af_in),
      .res (unp_res[g])
    );
    dau_packed #(.BASE(BASE), .SUB(g == 1)) u_pak (
      .al  (al_in),
      .ah  (ah_in),
      .af  (af_in),
      .cf  (cf_in),
      .res (pak_res[g])
    );
  end

  dau_prediv #(.BASE(BASE)) u_div (
    .al  (al_in),
    .ah  (ah_in),
    .res (div_res)
  );

  always_comb begin
    nxt    = '0;
    nxt.al = al_in;
    nxt.ah = ah_in;
    case (op)
      OP_UADD:   nxt = unp_res[0];
      OP_USUB:   nxt = unp_res[1];
      OP_PADD:   nxt = pak_res[0];
      OP_PSUB:   nxt = pak_res[1];
      OP_PREDIV: nxt = div_res;
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= start;
      if (start) res_q <= nxt;
    end
  end

  assign al_out = res_q.al;
  assign ah_out = res_q.ah;
  assign cf_out = res_q.cf;
  assign af_out = res_q.af;
  assign pf_out = res_q.pf;
  assign sf_out = res_q.sf;
  assign zf_out = res_q.zf;
  assign done   = done_q;

  assert_done_follows_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> done);
  assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done);
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(al_out) && $stable(ah_out) && $stable(cf_out)));
  assert_unpacked_add_hi_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (start && op == 3'd0) |=> (al_out[BYTE_W-1:NIB_W] == '0));
  assert_unpacked_sub_hi_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (start && op == 3'd1) |=> (al_out[BYTE_W-1:NIB_W] == '0));
  assert_packed_carry_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (start && (op == 3'd2 || op == 3'd3) && cf_in) |=> cf_out);
  assert_prediv_ah_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (start && op == 3'd4) |=> (ah_out == '0 && !cf_out && !af_out));
  assert_unpacked_flags_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (start && op <= 3'd1) |=> (!pf_out && !sf_out && !zf_out));
  assert_passthru_R10: assert property (@(posedge clk) disable iff (rst)
    (start && op >= 3'd5) |=> (al_out == $past(al_in) && ah_out == $past(ah_in)));
endmodule

// File: tb/sim_dau_top.sv
module sim_dau_top;
  localparam int PERIOD = 10;
  localparam int WD_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] al_in = '0;
  logic [7:0] ah_in = '0;
  logic       cf_in = 1'b0;
  logic       af_in = 1'b0;
  logic [7:0] al_out;
  logic [7:0] ah_out;
  logic       cf_out, af_out, pf_out, sf_out, zf_out, done;

  int checks = 0;
  int misses = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  dau_top u0 (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .al_in(al_in), .ah_in(ah_in), .cf_in(cf_in), .af_in(af_in),
    .al_out(al_out), .ah_out(ah_out), .cf_out(cf_out), .af_out(af_out),
    .pf_out(pf_out), .sf_out(sf_out), .zf_out(zf_out), .done(done)
  );

  // packed {al, ah, cf, af, pf, sf, zf}
  function automatic logic [20:0] model(input int o, input int a, input int h,
                                        input int c, input int x);
    int eal, eah, ecf, eaf, epf, esf, ezf, t, ones;
    bit lo, hi;
    eal = a; eah = h; ecf = 0; eaf = 0; epf = 0; esf = 0; ezf = 0;
    lo = ((a % 16) > 9) || (x != 0);
    case (o)
      0, 1: begin
        t = lo ? ((o == 0) ? a + 6 : a - 6) : a;
        eal = t & 15;
        eah = lo ? (((o == 0) ? h + 1 : h - 1) & 255) : h;
        ecf = lo; eaf = lo;
      end
      2, 3: begin
        hi = (a > 153) || (c != 0);
        t = lo ? ((o == 2) ? a + 6 : a - 6) : a;
        t = t & 255;
        t = hi ? ((o == 2) ? t + 96 : t - 96) : t;
        eal = t & 255;
        eaf = lo; ecf = hi;
      end
      4: begin
        eal = (h * 10 + a) & 255;
        eah = 0;
      end
      default: ;
    endcase
    if (o >= 2 && o <= 4) begin
      ones = 0;
      for (int b = 0; b < 8; b++) ones += (eal >> b) & 1;
      epf = (ones % 2 == 0);
      esf = (eal >> 7) & 1;
      ezf = (eal == 0);
    end
    return {8'(eal), 8'(eah), 1'(ecf), 1'(eaf), 1'(epf), 1'(esf), 1'(ezf)};
  endfunction

  function automatic string tag(input int o);
    case (o)
      0: return "R3/R9";
      1: return "R4/R9";
      2: return "R5/R7";
      3: return "R6/R7";
      4: return "R8/R7/R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check_res(input string req, input logic [20:0] exp);
    logic [20:0] act;
    act = {al_out, ah_out, cf_out, af_out, pf_out, sf_out, zf_out};
    checks++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s op=%0d al=%h ah=%h cf=%0b af=%0b: actual %h expected %h",
               req, op, al_in, ah_in, cf_in, af_in, act, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s done: actual %0b expected %0b", req, act, exp);
    end
  endtask

  initial begin
    logic [20:0] last;
    int ah_set [5] = '{8'h00, 8'h01, 8'h09, 8'h7F, 8'hFF};
    repeat (3) @(negedge clk);
    // R1: reset state
    check_res("R1", '0);
    check_bit("R1", done, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check_res("R1", '0);
    check_bit("R1", done, 1'b0);

    // Exhaustive sweep, one vector per cycle
    for (int o = 0; o < 8; o++) begin
      for (int hi = 0; hi < 5; hi++) begin
        for (int a = 0; a < 256; a++) begin
          for (int f = 0; f < 4; f++) begin
            op = 3'(o); al_in = 8'(a); ah_in = 8'(ah_set[hi]);
            cf_in = f[0]; af_in = f[1]; start = 1'b1;
            @(posedge clk);
            @(negedge clk);
            check_res(tag(o), model(o, a, ah_set[hi], f & 1, f >> 1));
            check_bit("R2", done, 1'b1);
          end
        end
      end
    end

    // R2: hold with start low, inputs changed
    start = 1'b0;
    last = {al_out, ah_out, cf_out, af_out, pf_out, sf_out, zf_out};
    op = 3'd4; al_in = 8'h55; ah_in = 8'h33; cf_in = 1'b1; af_in = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_res("R2", last);
      check_bit("R2", done, 1'b0);
    end

    // R2: isolated start gives a single-cycle done
    op = 3'd2; al_in = 8'h9A; ah_in = 8'h12; cf_in = 1'b0; af_in = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check_res("R5", model(2, 8'h9A, 8'h12, 0, 0));
    check_bit("R2", done, 1'b1);
    @(negedge clk);
    check_bit("R2", done, 1'b0);
    check_res("R2", model(2, 8'h9A, 8'h12, 0, 0));

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
      $finish;
    end
  end
endmodule